// File: doc/BRIEF.md
# Embedded Controller Host Port Interface

This block is the controller side of a two-port byte channel between a host processor and an embedded controller. The host sees a data port and a combined command/status port. It writes command bytes to the command port and argument bytes to the data port. It polls the status byte for two handshake flags: input-buffer-full (IBF) and output-buffer-full (OBF). An internal sequencer takes each byte one cycle after the host writes it. It decodes five commands and runs single-cycle read or write accesses to a 256-byte register space over a simple register-bus master port.

The block also keeps a burst-mode flag and a set of pending event flags that other logic raises. The host collects those events one at a time with the query command. While any event is pending, a level output is held high; it can serve as an interrupt or system-control request line.

Top module: `ecp_host_if`

## Requirements
- R1: After reset, the status byte is 0x00, the data port reads 0x00, `evt_pend_o` is low and `rb_req` is low.
- R2: A host write to either port sets IBF (status bit 1) on the next clock edge. IBF clears one edge later unless another write arrives. Status bit 3 is 1 when the last byte written went to the command port (`hst_port`=1) and 0 when it went to the data port.
- R3: Command 0x80 followed by a data byte A starts a register-bus read of address A. The value read is loaded into the data port and OBF (status bit 0) is set.
- R4: Command 0x81 followed by data bytes A and then D performs one register-bus write of D to address A.
- R5: A host read of the data port (`hst_rd` with `hst_port`=0) returns the loaded byte and clears OBF on that edge.
- R6: Command 0x82 sets the burst flag (status bit 4), loads 0x90 into the data port and sets OBF. Command 0x83 clears the burst flag and leaves OBF unchanged.
- R7: Command 0x84 loads the number of the lowest pending event into the data port and clears that event. Event input bit i has number i+1. If no event is pending, the command loads 0x00. In both cases OBF is set.
- R8: A command byte that arrives partway through a read or write sequence abandons that sequence, so its pending access never happens, and starts the new command.
- R9: A data byte that arrives with no sequence open has no effect. An unknown command code (0x00–0x7F or 0x85–0xFF) closes any open sequence and has no other effect. The register bus is used only in the cycle after a data-port write that completes a read or write sequence.
- R10: A pulse on `evt_set` bit i latches event i as pending. `evt_pend_o` and status bit 5 are high while any event is pending.
- R11: Each register-bus access is a one-cycle `rb_req` pulse, issued in the cycle in which IBF for the final byte is high. Read data is taken from `rb_rdata` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_wr | input | 1 | Host write strobe, one byte per cycle it is high |
| hst_rd | input | 1 | Host read strobe; a read of the data port clears OBF |
| hst_port | input | 1 | Port select: 0 data port, 1 command/status port |
| hst_wdata | input | 8 | Byte written by the host |
| hst_rdata | output | 8 | Data port byte, or the status byte when `hst_port`=1 |
| rb_req | output | 1 | Register-bus access strobe |
| rb_we | output | 1 | Register-bus write enable |
| rb_addr | output | 8 | Register-bus address |
| rb_wdata | output | 8 | Register-bus write data |
| rb_rdata | input | 8 | Register-bus read data, valid in the request cycle |
| evt_set | input | NEV | Event raise pulses, one bit per event |
| evt_pend_o | output | 1 | Level request: at least one event pending |

## Verification
A sequencer stuck in a wrong state shows up within one transaction. Either the next read loads a byte different from the one stored in the register model, or a write lands at the wrong address or does not happen at all, and either effect is visible a single cycle after the final byte. Handshake faults appear in the status byte at the next sampled cycle: an IBF that stays set, an OBF that survives a data-port read, or a wrong command/data bit. A fault in the event store appears on the very next query, because the numbers come back in a sequence the bench predicts from the raised bit pattern.

// File: rtl/ecp_pkg.sv
// Shared encodings for the host port interface: sequencer states,
// command codes, the burst acknowledge byte and the status bit positions.
package ecp_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RADR = 2'd1,
        SQ_WADR = 2'd2,
        SQ_WDAT = 2'd3
    } seq_st_t;

    localparam logic [7:0] OP_READ  = 8'h80;
    localparam logic [7:0] OP_WRITE = 8'h81;
    localparam logic [7:0] OP_BON   = 8'h82;
    localparam logic [7:0] OP_BOFF  = 8'h83;
    localparam logic [7:0] OP_QUERY = 8'h84;
    localparam logic [7:0] BURST_ACK = 8'h90;

    localparam int SB_OBF   = 0;
    localparam int SB_IBF   = 1;
    localparam int SB_CMD   = 3;
    localparam int SB_BURST = 4;
    localparam int SB_EVT   = 5;
endpackage

// File: rtl/ecp_hostport.sv
// Host-facing buffers and handshake flags.
// Assumes: one host access per cycle. A write made while IBF is still
// set replaces the unconsumed byte. A sequencer load of the output
// buffer wins over a host read in the same cycle.
module ecp_hostport #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hst_wr,
    input  logic          hst_rd,
    input  logic          hst_port,
    input  logic [DW-1:0] hst_wdata,
    input  logic          ld_obuf,
    input  logic [DW-1:0] ld_val,
    input  logic          burst,
    input  logic          evt_any,
    output logic          ibf,
    output logic          obf,
    output logic          cmd_flag,
    output logic [DW-1:0] inbuf,
    output logic [DW-1:0] hst_rdata
);
    import ecp_pkg::*;

    logic [DW-1:0] obuf;
    logic [DW-1:0] status;

    // Input side: latch the host byte; IBF drops once the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf      <= 1'b0;
            cmd_flag <= 1'b0;
            inbuf    <= '0;
        end else if (hst_wr) begin
            ibf      <= 1'b1;
            cmd_flag <= hst_port;
            inbuf    <= hst_wdata;
        end else if (ibf) begin
            ibf <= 1'b0;
        end
    end

    // Output side: sequencer loads set OBF; a host data-port read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obf  <= 1'b0;
            obuf <= '0;
        end else if (ld_obuf) begin
            obf  <= 1'b1;
            obuf <= ld_val;
        end else if (hst_rd && !hst_port) begin
            obf <= 1'b0;
        end
    end

    // Status assembly and port read mux.
    always_comb begin
        status           = '0;
        status[SB_OBF]   = obf;
        status[SB_IBF]   = ibf;
        status[SB_CMD]   = cmd_flag;
        status[SB_BURST] = burst;
        status[SB_EVT]   = evt_any;
        hst_rdata        = hst_port ? status : obuf;
    end
endmodule

// File: rtl/ecp_evq.sv
// Pending-event store with a lowest-number-first query.
// Assumes: event bit i is reported as number i+1 and NEV stays below 256.
// A raise and a take of the same event in one cycle leave it pending.
module ecp_evq #(
    parameter int NEV = 8,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] evt_set,
    input  logic           take,
    output logic [DW-1:0]  low_num,
    output logic           any
);
    logic [NEV-1:0] pend;
    logic [NEV-1:0] low_hot;

    // Isolate the lowest pending bit and encode its number.
    always_comb begin
        low_hot = pend & (~pend + 1'b1);
        low_num = '0;
        for (int i = NEV - 1; i >= 0; i--) begin
            if (pend[i]) low_num = DW'(i + 1);
        end
    end

    // One flop per event: raise on a pulse, drop when the query takes it.
    for (genvar g = 0; g < NEV; g++) begin : g_ev
        always_ff @(posedge clk) begin
            if (!rst_n)           pend[g] <= 1'b0;
            else if (evt_set[g])  pend[g] <= 1'b1;
            else if (take && low_hot[g]) pend[g] <= 1'b0;
        end
    end

    assign any = |pend;
endmodule

// File: rtl/ecp_seq.sv
// Command sequencer: takes one buffered byte per cycle while IBF is set,
// decodes commands and drives single-cycle register-bus accesses.
// Assumes: rb_rdata is valid combinationally in the request cycle.
module ecp_seq #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ibf,
    input  logic          cmd_flag,
    input  logic [DW-1:0] inbuf,
    input  logic [DW-1:0] rb_rdata,
    input  logic [DW-1:0] qry_num,
    output logic          rb_req,
    output logic          rb_we,
    output logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_wdata,
    output logic          ld_obuf,
    output logic [DW-1:0] ld_val,
    output logic          qry_take,
    output logic          burst
);
    import ecp_pkg::*;

    seq_st_t       st, st_nx;
    logic [AW-1:0] adr_q;
    logic          burst_nx;

    // Decode the byte being taken and choose outputs and next state.
    always_comb begin
        st_nx    = st;
        burst_nx = burst;
        rb_req   = 1'b0;
        rb_we    = 1'b0;
        rb_addr  = adr_q;
        rb_wdata = inbuf;
        ld_obuf  = 1'b0;
        ld_val   = rb_rdata;
        qry_take = 1'b0;
        if (ibf && cmd_flag) begin
            st_nx = SQ_IDLE;
            case (inbuf)
                OP_READ:  st_nx = SQ_RADR;
                OP_WRITE: st_nx = SQ_WADR;
                OP_BON: begin
                    burst_nx = 1'b1;
                    ld_obuf  = 1'b1;
                    ld_val   = BURST_ACK;
                end
                OP_BOFF:  burst_nx = 1'b0;
                OP_QUERY: begin
                    ld_obuf  = 1'b1;
                    ld_val   = qry_num;
                    qry_take = 1'b1;
                end
                default: ;
            endcase
        end else if (ibf) begin
            case (st)
                SQ_RADR: begin
                    rb_req  = 1'b1;
                    rb_addr = AW'(inbuf);
                    ld_obuf = 1'b1;
                    st_nx   = SQ_IDLE;
                end
                SQ_WADR: st_nx = SQ_WDAT;
                SQ_WDAT: begin
                    rb_req = 1'b1;
                    rb_we  = 1'b1;
                    st_nx  = SQ_IDLE;
                end
                default: ;
            endcase
        end
    end

    // Sequencer state, captured write address and burst flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SQ_IDLE;
            adr_q <= '0;
            burst <= 1'b0;
        end else begin
            st    <= st_nx;
            burst <= burst_nx;
            if (ibf && !cmd_flag && st == SQ_WADR) adr_q <= AW'(inbuf);
        end
    end
endmodule

// File: rtl/ecp_host_if.sv
// Top of the host port interface: host buffers, command sequencer and
// event store. Assumes a single clock domain with the host strobes
// already synchronous to clk.
module ecp_host_if #(
    parameter int DW  = 8,
    parameter int AW  = 8,
    parameter int NEV = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hst_wr,
    input  logic           hst_rd,
    input  logic           hst_port,
    input  logic [DW-1:0]  hst_wdata,
    output logic [DW-1:0]  hst_rdata,
    output logic           rb_req,
    output logic           rb_we,
    output logic [AW-1:0]  rb_addr,
    output logic [DW-1:0]  rb_wdata,
    input  logic [DW-1:0]  rb_rdata,
    input  logic [NEV-1:0] evt_set,
    output logic           evt_pend_o
);
    logic          ibf_w, obf_w, cmd_w, burst_w, ld_w, take_w;
    logic [DW-1:0] inbuf_w, ldv_w, num_w;

    ecp_hostport #(.DW(DW)) u_port (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_port(hst_port), .hst_wdata(hst_wdata), .ld_obuf(ld_w),
        .ld_val(ldv_w), .burst(burst_w), .evt_any(evt_pend_o),
        .ibf(ibf_w), .obf(obf_w), .cmd_flag(cmd_w), .inbuf(inbuf_w),
        .hst_rdata(hst_rdata)
    );

    ecp_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ibf(ibf_w), .cmd_flag(cmd_w),
        .inbuf(inbuf_w), .rb_rdata(rb_rdata), .qry_num(num_w),
        .rb_req(rb_req), .rb_we(rb_we), .rb_addr(rb_addr),
        .rb_wdata(rb_wdata), .ld_obuf(ld_w), .ld_val(ldv_w),
        .qry_take(take_w), .burst(burst_w)
    );

    ecp_evq #(.NEV(NEV), .DW(DW)) u_evq (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .take(take_w),
        .low_num(num_w), .any(evt_pend_o)
    );
endmodule

// File: rtl/ecp_host_if_chk.sv
// Protocol checker for ecp_host_if, attached by bind. It observes the
// handshake flags and the register-bus strobe over time.
module ecp_host_if_chk #(
    parameter int NEV = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hst_wr,
    input logic           hst_rd,
    input logic           hst_port,
    input logic           ibf,
    input logic           obf,
    input logic           cmd_flag,
    input logic           burst,
    input logic           rb_req,
    input logic [NEV-1:0] evt_set,
    input logic           evt_pend
);
    // R2
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_wr |=> ibf);
    // R2
    ibf_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && !hst_wr) |=> !ibf);
    // R11
    rb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req |=> !rb_req);
    // R9
    rb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req |-> $past(hst_wr && !hst_port));
    // R5
    obf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(obf) |-> $past(hst_rd && !hst_port));
    // R6
    burst_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(burst) |-> $past(ibf && cmd_flag));
    // R10
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_pend) |-> $past(|evt_set));
endmodule

bind ecp_host_if ecp_host_if_chk #(.NEV(NEV)) u_chk (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_port(hst_port), .ibf(ibf_w), .obf(obf_w), .cmd_flag(cmd_w),
    .burst(burst_w), .rb_req(rb_req), .evt_set(evt_set),
    .evt_pend(evt_pend_o)
);

// File: tb/sim_ecp_host_if.sv
// Bench: full address sweep through the byte protocol, all 256 event
// patterns through the query command, plus handshake and abort cases.
module sim_ecp_host_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hst_wr = 1'b0, hst_rd = 1'b0, hst_port = 1'b0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata;
    logic       rb_req, rb_we;
    logic [7:0] rb_addr, rb_wdata, rb_rdata;
    logic [7:0] evt_set = '0;
    logic       evt_pend_o;

    logic [7:0] mem [256];
    int         rb_cnt = 0;
    int         checks = 0, failures = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    ecp_host_if u0 (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_port(hst_port), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .rb_req(rb_req), .rb_we(rb_we), .rb_addr(rb_addr),
        .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .evt_set(evt_set),
        .evt_pend_o(evt_pend_o)
    );

    // Register space model seen through the bus port.
    assign rb_rdata = mem[rb_addr];
    always @(posedge clk) begin
        if (rst_n && rb_req) begin
            rb_cnt <= rb_cnt + 1;
            if (rb_we) mem[rb_addr] <= rb_wdata;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic p, input logic [7:0] b);
        @(negedge clk); hst_port = p; hst_wdata = b; hst_wr = 1'b1;
        @(negedge clk); hst_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic peek(output logic [7:0] s);
        hst_port = 1'b1; #1; s = hst_rdata;
    endtask

    task automatic hrd(output logic [7:0] v);
        @(negedge clk); hst_port = 1'b0; hst_rd = 1'b1; #1; v = hst_rdata;
        @(negedge clk); hst_rd = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ 8'h5A);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, v;
        int base, exp_n;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'hA5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek(s); chk("R1 status", s, 8'h00);
        hst_port = 1'b0; #1; chk("R1 data", hst_rdata, 8'h00);
        chk("R1 pend", evt_pend_o, 0);
        chk("R1 rb_req", rb_req, 0);

        // R2 IBF timing and R11 strobe cycle, checked by hand
        @(negedge clk); hst_port = 1'b1; hst_wdata = 8'h81; hst_wr = 1'b1;
        @(negedge clk); hst_wr = 1'b0; peek(s);
        chk("R2 ibf set", s[1], 1); chk("R2 cmd bit", s[3], 1);
        @(negedge clk); peek(s); chk("R2 ibf clear", s[1], 0);
        @(negedge clk); hst_port = 1'b0; hst_wdata = 8'h10; hst_wr = 1'b1;
        @(negedge clk); hst_wr = 1'b0; peek(s);
        chk("R2 data bit", s[3], 0);
        @(negedge clk); hst_port = 1'b0; hst_wdata = 8'hC3; hst_wr = 1'b1;
        @(negedge clk); hst_wr = 1'b0;
        chk("R11 req", rb_req, 1); chk("R11 we", rb_we, 1);
        chk("R11 addr", rb_addr, 8'h10); chk("R11 wdata", rb_wdata, 8'hC3);
        @(negedge clk); chk("R11 single", rb_req, 0);
        chk("R4 first write", mem[16], 8'hC3);

        // R4 sweep: write every address
        base = rb_cnt;
        for (int a = 0; a < 256; a++) begin
            hw(1, 8'h81); hw(0, 8'(a)); hw(0, pat(a));
            chk("R4 write", mem[a], pat(a));
        end
        chk("R4 count", rb_cnt - base, 256);
        // R3/R5 sweep: read every address back
        for (int a = 0; a < 256; a++) begin
            hw(1, 8'h80); hw(0, 8'(a));
            peek(s); chk("R3 obf", s[0], 1);
            hrd(v); chk("R3 data", v, pat(a));
            peek(s); chk("R5 obf clear", s[0], 0);
            hst_port = 1'b0; #1; chk("R5 data kept", hst_rdata, pat(a));
        end

        // R6 burst on/off
        hw(1, 8'h82); peek(s);
        chk("R6 burst on", s[4], 1); chk("R6 obf", s[0], 1);
        hrd(v); chk("R6 ack", v, 8'h90);
        hw(1, 8'h83); peek(s);
        chk("R6 burst off", s[4], 0); chk("R6 obf kept", s[0], 0);

        // R8 abort: write sequence cut by a read command
        base = rb_cnt;
        hw(1, 8'h81); hw(0, 8'h20); hw(1, 8'h80); hw(0, 8'h21);
        chk("R8 one access", rb_cnt - base, 1);
        chk("R8 no write", mem[32], pat(32));
        hrd(v); chk("R8 read", v, pat(33));
        hw(1, 8'h80); hw(1, 8'h81); hw(0, 8'h22); hw(0, 8'h77);
        chk("R8 write after abort", mem[34], 8'h77);
        hw(0, 8'h66);
        chk("R8 trailing data", mem[34], 8'h77);

        // R9 stray data and unknown command
        base = rb_cnt;
        hw(0, 8'h05); peek(s);
        chk("R9 idle data", rb_cnt - base, 0); chk("R9 obf", s[0], 0);
        hw(1, 8'h81); hw(0, 8'h30); hw(1, 8'h85); hw(0, 8'hEE);
        chk("R9 unknown", rb_cnt - base, 0);
        chk("R9 mem", mem[48], pat(48));
        peek(s); chk("R9 obf2", s[0], 0);

        // R7/R10 all event patterns
        for (int p = 0; p < 256; p++) begin
            @(negedge clk); evt_set = 8'(p);
            @(negedge clk); evt_set = '0;
            chk("R10 pend", evt_pend_o, (p != 0) ? 1 : 0);
            peek(s); chk("R10 status", s[5], (p != 0) ? 1 : 0);
            for (int k = 0; k < 8; k++) begin
                if (p[k]) begin
                    hw(1, 8'h84); peek(s); chk("R7 obf", s[0], 1);
                    hrd(v); exp_n = k + 1; chk("R7 number", v, exp_n);
                end
            end
            hw(1, 8'h84); hrd(v); chk("R7 empty", v, 0);
            chk("R10 idle", evt_pend_o, 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule